// File: doc/BRIEF.md
# Asynchronous Bus Cycle Master with Late Error and Retry

This block is a bus master for an asynchronous, handshake-terminated bus. It accepts one access at a time from a requester: address, function code, transfer size, direction and write data. It then runs the access on the bus through a fixed sequence of clocked states, S0 to S5. The bus side drives address strobe, data strobe, read/write, address, function code, size and write data with an output enable. It watches three active-high termination inputs: acknowledge, bus error and halt. Each of these inputs passes through a two-flop synchronizer before the state machine acts on it.

A cycle ends in one of three ways. An acknowledge alone ends it normally. A bus error ends it as an error, and the bus error wins over an acknowledge. A bus error together with halt makes the master drop its strobes, wait until both signals are released, and run the same access again. A bus error, or a bus error with halt, still counts when it is first seen one synchronized sample after the acknowledge. Read data is captured when the acknowledge is acted on, and it is only committed once that late sample shows no error. The requester gets a one-cycle done pulse with a two-bit status.

Top module: `async_bus_master`

## Requirements
- R1: After reset, address strobe, data strobe, output enable and done are low, read/write is high (read), and req_ready_o is high while no termination input is asserted.
- R2: A cycle ended by acknowledge alone gives a one-cycle done_o with status 2'b00 in the first clock where address strobe is low again. For a read, rdata_o then holds the bus read data.
- R3: During a write cycle, whenever data strobe is asserted, the output enable is high and bus_wdata_o holds the requested write data, unchanged.
- R4: Bus error seen together with, or without, acknowledge (halt low) ends the cycle with status 2'b01, and rdata_o keeps its previous value.
- R5: A bus error first asserted one clock after acknowledge still ends the cycle with status 2'b01. A bus error first asserted two clocks after acknowledge is ignored (status 2'b00, read data committed).
- R6: Bus error with halt negates both strobes without a done pulse and starts no new cycle. The access is then run again and reported with status 2'b10 when the rerun ends with acknowledge.
- R7: No bus cycle starts (address strobe stays low) while a synchronized bus error or halt is still asserted, whether the master is idle or waiting to retry.
- R8: Every attempt of a retried access drives the same address, function code, size and direction as the first attempt.
- R9: Bus error with halt first asserted one clock after acknowledge causes a retry, not an error, and the read data of the aborted attempt is not reported.
- R10: If bus error alone is seen during the rerun of a retried access, that access ends with status 2'b01.
- R11: done_o is never high for two consecutive cycles, data strobe is never asserted without address strobe, and status 2'b11 is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Requester presents an access |
| req_ready_o | output | 1 | Master idle and bus quiet; access taken when valid |
| req_addr_i | input | AW | Access address |
| req_fc_i | input | FCW | Access function code |
| req_size_i | input | SW | Access size code |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DW | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 00 normal, 01 bus error, 10 retried then normal; valid with done_o |
| rdata_o | output | DW | Last committed read data |
| bus_as_o | output | 1 | Address strobe, active high |
| bus_ds_o | output | 1 | Data strobe, active high |
| bus_rw_o | output | 1 | 1 = read, 0 = write |
| bus_oe_o | output | 1 | Write data output enable |
| bus_addr_o | output | AW | Bus address |
| bus_fc_o | output | FCW | Bus function code |
| bus_size_o | output | SW | Bus size code |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdata_i | input | DW | Bus read data |
| bus_ack_i | input | 1 | Asynchronous acknowledge |
| bus_err_i | input | 1 | Asynchronous bus error |
| bus_halt_i | input | 1 | Asynchronous halt |

## Verification
The termination logic is driven with a plain acknowledge, acknowledge together with bus error, bus error alone, and bus error one clock and two clocks after acknowledge. Together these separate the priority rule, the single late sample window and its upper edge. Bus error with halt is applied both at once and one clock after acknowledge, to show that a retry is not an error and that an aborted read is never committed. A rerun that itself meets a bus error shows that retry and error status compose. An idle master held off by halt shows that no cycle starts until the bus is quiet.

// File: rtl/async_bus_master.sv
module async_bus_master #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int FCW = 3,
  parameter int SW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [FCW-1:0] req_fc_i,
  input  logic [SW-1:0]  req_size_i,
  input  logic           req_wr_i,
  input  logic [DW-1:0]  req_wdata_i,
  output logic           done_o,
  output logic [1:0]     status_o,
  output logic [DW-1:0]  rdata_o,
  output logic           bus_as_o,
  output logic           bus_ds_o,
  output logic           bus_rw_o,
  output logic           bus_oe_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [FCW-1:0] bus_fc_o,
  output logic [SW-1:0]  bus_size_o,
  output logic [DW-1:0]  bus_wdata_o,
  input  logic [DW-1:0]  bus_rdata_i,
  input  logic           bus_ack_i,
  input  logic           bus_err_i,
  input  logic           bus_halt_i
);
  localparam logic [1:0] STAT_OK    = 2'b00;
  localparam logic [1:0] STAT_BERR  = 2'b01;
  localparam logic [1:0] STAT_RETRY = 2'b10;

  typedef enum logic [2:0] {
    PH_IDLE, PH_S0, PH_S1, PH_S2, PH_S3, PH_S4, PH_S5, PH_HOLD
  } phase_t;

  phase_t ph_q, ph_d;

  logic [2:0] sy1_q, sy2_q;
  logic ack_s, err_s, halt_s;

  logic [AW-1:0]  addr_q;
  logic [FCW-1:0] fc_q;
  logic [SW-1:0]  size_q;
  logic           wr_q;
  logic [DW-1:0]  wdata_q;
  logic [DW-1:0]  cap_q;
  logic [DW-1:0]  rdata_q;
  logic           fail_q;
  logic           retried_q;
  logic           take;
  logic           in_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1_q <= '0;
      sy2_q <= '0;
    end else begin
      sy1_q <= {bus_halt_i, bus_err_i, bus_ack_i};
      sy2_q <= sy1_q;
    end
  end

  assign ack_s  = sy2_q[0];
  assign err_s  = sy2_q[1];
  assign halt_s = sy2_q[2];

  assign req_ready_o = (ph_q == PH_IDLE) && !ack_s && !err_s && !halt_s;
  assign take        = req_valid_i && req_ready_o;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE: if (take) ph_d = PH_S0;
      PH_S0:   ph_d = PH_S1;
      PH_S1:   ph_d = PH_S2;
      PH_S2: begin
        if (err_s && halt_s)  ph_d = PH_HOLD;
        else if (err_s)       ph_d = PH_S5;
        else if (ack_s)       ph_d = PH_S3;
      end
      PH_S3: begin
        if (err_s && halt_s)  ph_d = PH_HOLD;
        else if (err_s)       ph_d = PH_S5;
        else                  ph_d = PH_S4;
      end
      PH_S4:   ph_d = PH_S5;
      PH_S5:   ph_d = PH_IDLE;
      PH_HOLD: if (!err_s && !halt_s) ph_d = PH_S0;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      addr_q    <= '0;
      fc_q      <= '0;
      size_q    <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      cap_q     <= '0;
      rdata_q   <= '0;
      fail_q    <= 1'b0;
      retried_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (take) begin
        addr_q    <= req_addr_i;
        fc_q      <= req_fc_i;
        size_q    <= req_size_i;
        wr_q      <= req_wr_i;
        wdata_q   <= req_wdata_i;
        retried_q <= 1'b0;
      end
      if (ph_d == PH_S0)
        fail_q <= 1'b0;
      if ((ph_q == PH_S2 || ph_q == PH_S3) && ph_d == PH_HOLD)
        retried_q <= 1'b1;
      if ((ph_q == PH_S2 || ph_q == PH_S3) && ph_d == PH_S5)
        fail_q <= 1'b1;
      if (ph_q == PH_S3)
        cap_q <= bus_rdata_i;
      if (ph_q == PH_S4 && !wr_q)
        rdata_q <= cap_q;
    end
  end

  assign in_strobe = (ph_q == PH_S2) || (ph_q == PH_S3) || (ph_q == PH_S4);

  assign bus_as_o    = (ph_q == PH_S1) || in_strobe;
  assign bus_ds_o    = in_strobe || (ph_q == PH_S1 && !wr_q);
  assign bus_oe_o    = wr_q && in_strobe;
  assign bus_rw_o    = !(wr_q && ph_q != PH_IDLE && ph_q != PH_HOLD);
  assign bus_addr_o  = addr_q;
  assign bus_fc_o    = fc_q;
  assign bus_size_o  = size_q;
  assign bus_wdata_o = wdata_q;

  assign done_o   = (ph_q == PH_S5);
  assign status_o = fail_q ? STAT_BERR : (retried_q ? STAT_RETRY : STAT_OK);
  assign rdata_o  = rdata_q;
endmodule

module async_bus_master_chk #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int FCW = 3,
  parameter int SW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           done_o,
  input logic [1:0]     status_o,
  input logic           bus_as_o,
  input logic           bus_ds_o,
  input logic           bus_rw_o,
  input logic           bus_oe_o,
  input logic [DW-1:0]  bus_wdata_o,
  input logic           bus_err_i,
  input logic           bus_halt_i
);
  logic hold_q1, hold_q2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q1 <= 1'b0;
      hold_q2 <= 1'b0;
    end else begin
      hold_q1 <= bus_err_i || bus_halt_i;
      hold_q2 <= hold_q1;
    end
  end

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r11_ds_needs_as: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ds_o |-> bus_as_o);
  a_r11_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> status_o != 2'b11);
  a_r3_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ds_o && !bus_rw_o) |-> bus_oe_o);
  a_r3_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe_o && $past(bus_oe_o)) |-> $stable(bus_wdata_o));
  a_r7_no_start_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_o) |-> !$past(hold_q2, 2));
endmodule

bind async_bus_master async_bus_master_chk #(
  .AW(AW), .DW(DW), .FCW(FCW), .SW(SW)
) chk_i (.*);

// File: tb/async_bus_master_tb.sv
module async_bus_master_tb_top;
  localparam int AW = 32, DW = 32, FCW = 3, SW = 2;
  localparam int NV = 9;

  localparam logic [3:0]  V_MODE [NV] = '{4'd0, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7};
  localparam logic        V_WR   [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] V_ADDR [NV] = '{32'h1000_0004, 32'h2000_0010, 32'h3000_0020, 32'h3000_0024,
                                          32'h4000_0100, 32'h5000_0200, 32'h6000_0300, 32'h7000_0400,
                                          32'h8000_0500};
  localparam logic [31:0] V_DATA [NV] = '{32'hA5A5_0001, 32'h1234_5678, 32'hDEAD_0002, 32'hDEAD_0003,
                                          32'h0BAD_F00D, 32'hC0DE_0005, 32'hBEEF_0006, 32'h5555_AAAA,
                                          32'hFACE_0008};
  localparam logic [1:0]  V_STAT [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b00, 2'b01, 2'b01};
  localparam int          V_TRY  [NV] = '{1, 1, 1, 1, 2, 2, 1, 1, 2};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid_i = 1'b0, req_wr_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [FCW-1:0] req_fc_i = '0;
  logic [SW-1:0] req_size_i = '0;
  logic [DW-1:0] req_wdata_i = '0, bus_rdata_i = '0;
  logic bus_ack_i = 1'b0, bus_err_i = 1'b0, bus_halt_i = 1'b0;
  logic req_ready_o, done_o, bus_as_o, bus_ds_o, bus_rw_o, bus_oe_o;
  logic [1:0] status_o;
  logic [DW-1:0] rdata_o, bus_wdata_o;
  logic [AW-1:0] bus_addr_o;
  logic [FCW-1:0] bus_fc_o;
  logic [SW-1:0] bus_size_o;

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_rd = '0;

  always #2 clk = ~clk;

  async_bus_master #(.AW(AW), .DW(DW), .FCW(FCW), .SW(SW)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic release_bus();
    bus_ack_i = 1'b0; bus_err_i = 1'b0; bus_halt_i = 1'b0;
  endtask

  task automatic run_vec(input int i);
    logic [3:0] m;
    int tries = 0;
    bit fin = 0;
    logic [FCW-1:0] fc = FCW'(i + 1);
    logic [SW-1:0] sz = SW'(i);
    do @(negedge clk); while (!req_ready_o);
    req_addr_i = V_ADDR[i]; req_fc_i = fc; req_size_i = sz;
    req_wr_i = V_WR[i]; req_wdata_i = V_DATA[i]; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    while (!fin && tries < 3) begin
      do @(negedge clk); while (!bus_ds_o);
      tries++;
      if (tries == 1) m = (V_MODE[i] == 4'd7) ? 4'd3 : V_MODE[i];
      else            m = (V_MODE[i] == 4'd7) ? 4'd6 : 4'd0;
      chk(bus_addr_o == V_ADDR[i] && bus_fc_o == fc && bus_size_o == sz && bus_rw_o == !V_WR[i],
          "R8 access info per attempt", {bus_addr_o, 27'd0, bus_fc_o, bus_size_o}, {V_ADDR[i], 27'd0, fc, sz});
      if (V_WR[i])
        chk(bus_oe_o && bus_wdata_o == V_DATA[i], "R3 write data driven", {31'd0, bus_oe_o, bus_wdata_o},
            {32'd1, V_DATA[i]});
      bus_rdata_i = V_DATA[i];
      case (m)
        4'd0: bus_ack_i = 1'b1;
        4'd1: begin bus_ack_i = 1'b1; bus_err_i = 1'b1; end
        4'd2: begin bus_ack_i = 1'b1; @(negedge clk); bus_err_i = 1'b1; end
        4'd3: begin bus_err_i = 1'b1; bus_halt_i = 1'b1; end
        4'd4: begin bus_ack_i = 1'b1; @(negedge clk); bus_err_i = 1'b1; bus_halt_i = 1'b1; end
        4'd5: begin bus_ack_i = 1'b1; @(negedge clk); @(negedge clk); bus_err_i = 1'b1; end
        default: bus_err_i = 1'b1;
      endcase
      while (bus_as_o) @(negedge clk);
      if (m == 4'd3 || m == 4'd4) begin
        chk(!done_o, "R6 no done on retry abort", 64'(done_o), 64'd0);
        for (int k = 0; k < 4; k++) begin
          chk(!bus_as_o && !bus_ds_o, "R7 bus quiet while error and halt held", 64'(bus_as_o), 64'd0);
          @(negedge clk);
        end
        release_bus();
      end else begin
        fin = 1;
        chk(done_o, "R2 done at strobe negation", 64'(done_o), 64'd1);
        chk(status_o == V_STAT[i], $sformatf("R2/R4/R5/R6/R10 status vec %0d", i),
            64'(status_o), 64'(V_STAT[i]));
        release_bus();
        @(negedge clk);
        chk(!done_o, "R11 done one cycle", 64'(done_o), 64'd0);
        if (!V_WR[i] && V_STAT[i] != 2'b01) exp_rd = V_DATA[i];
        chk(rdata_o == exp_rd, $sformatf("R4/R5/R9 read data vec %0d", i), 64'(rdata_o), 64'(exp_rd));
      end
    end
    chk(tries == V_TRY[i], $sformatf("R6 attempt count vec %0d", i), 64'(tries), 64'(V_TRY[i]));
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_as_o && !bus_ds_o && !bus_oe_o && !done_o && bus_rw_o && req_ready_o, "R1 reset state",
        {58'd0, bus_as_o, bus_ds_o, bus_oe_o, done_o, bus_rw_o, req_ready_o}, 64'h3);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R7: halt held while idle keeps a pending request from starting
    bus_halt_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(!req_ready_o, "R7 not ready under halt", 64'(req_ready_o), 64'd0);
    req_addr_i = 32'h9000_0000; req_wr_i = 1'b0; req_valid_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!bus_as_o, "R7 no cycle start under halt", 64'(bus_as_o), 64'd0);
    end
    req_valid_i = 1'b0;
    bus_halt_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready_o, "R7 ready after halt release", 64'(req_ready_o), 64'd1);
    run_vec(0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule